// File: doc/BRIEF.md
# System Control Register Bank

This block is a 32-bit register slave that sits in a 4 KB address window on a development board. Software uses it to set two board LEDs, read the state of the push buttons, and program a control word that other peripherals on the board pick up. It also keeps two running time counters, one at 1 Hz and one at 100 Hz, and a prescaled event counter pair made of a programmable reload value, a down-counter and an event counter. Every counter value can be overwritten by software, and counting carries on from the value written.

All time bases come from the single system clock. Rate dividers built from the `CLK_HZ` and `PS_HZ` parameters turn it into enable pulses. A write to a counter restarts that counter's divider phase, so the first increment after a load comes one full period later. The bus is a plain single-cycle port with no wait states. Read data appears on the clock edge that accepts the read and is held until the next read.

Top module: `sysctl_regbank`

## Requirements
- R1: A write to offset 0x000 stores wdata[1:0] in the LED register. That register drives `led_o`, and a read of 0x000 returns it with bits 31:2 zero.
- R2: Offset 0x04C holds a 32-bit control word that reads back exactly as last written and drives `misc_o`.
- R3: A read of offset 0x008 returns the button inputs after a SYNC_STAGES-flop synchroniser in bits BTN_W-1:0, with the upper bits zero. Writes to 0x008 change nothing.
- R4: The 100 Hz counter at 0x014 increments once every CLK_HZ/100 cycles and wraps modulo 2^32. A write loads a new value, and the next increment follows CLK_HZ/100 cycles after the write.
- R5: The 1 Hz counter at 0x010 increments once every CLK_HZ cycles. A write loads a new value, and the next increment follows CLK_HZ cycles after the write.
- R6: On each prescale tick (one every CLK_HZ/PS_HZ cycles), a nonzero down-counter (0x020) decrements by one. A zero down-counter reloads from the reload register (0x01C), and the event counter (0x018) increments at that same tick.
- R7: With a reload value of zero, the down-counter stays at zero once it reaches zero, and the event counter increments on every prescale tick, wrapping modulo 2^32.
- R8: A write to the reload, down-counter or event counter register loads the written value, and the reload register reads back as written. A write to any of these three registers restarts the prescale tick phase.
- R9: A read at any other offset, including unaligned offsets, returns zero. A write there changes no register.
- R10: Reset clears the LED, control word, reload, down-counter, event counter and both time counters to zero.
- R11: `bus_rdata` changes only on a clock edge where a read is accepted, and it holds its value through idle cycles and writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| btn_i | input | BTN_W | Asynchronous push-button levels |
| led_o | output | 2 | LED drive bits |
| misc_o | output | 32 | Control word for other peripherals |

## Verification
The assertions assume that `bus_sel`, `bus_wr`, `bus_addr` and `bus_wdata` are stable around each clock edge. They also assume that `rst_n` is released while those inputs are idle. The step properties on the counters assume that no load lands in the cycle they watch, so they are gated by the matching write decode. The stimulus keeps to these assumptions by changing every bus input on the falling edge. It issues one access per cycle, releases reset with the bus idle, and moves the buttons only between accesses.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   localparam int unsigned WIN_AW = 12;
   localparam int unsigned DW     = 32;

   localparam logic [WIN_AW-1:0] OFS_LED    = 12'h000;
   localparam logic [WIN_AW-1:0] OFS_BTN    = 12'h008;
   localparam logic [WIN_AW-1:0] OFS_SLOW   = 12'h010;
   localparam logic [WIN_AW-1:0] OFS_FAST   = 12'h014;
   localparam logic [WIN_AW-1:0] OFS_EVT    = 12'h018;
   localparam logic [WIN_AW-1:0] OFS_RELOAD = 12'h01C;
   localparam logic [WIN_AW-1:0] OFS_DOWN   = 12'h020;
   localparam logic [WIN_AW-1:0] OFS_MISC   = 12'h04C;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_LED,
      SEL_BTN,
      SEL_SLOW,
      SEL_FAST,
      SEL_EVT,
      SEL_RELOAD,
      SEL_DOWN,
      SEL_MISC
   } reg_sel_e;

   function automatic reg_sel_e decode_offset(input logic [WIN_AW-1:0] a);
      reg_sel_e s;
      case (a)
         OFS_LED:    s = SEL_LED;
         OFS_BTN:    s = SEL_BTN;
         OFS_SLOW:   s = SEL_SLOW;
         OFS_FAST:   s = SEL_FAST;
         OFS_EVT:    s = SEL_EVT;
         OFS_RELOAD: s = SEL_RELOAD;
         OFS_DOWN:   s = SEL_DOWN;
         OFS_MISC:   s = SEL_MISC;
         default:    s = SEL_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/sysctl_rate_div.sv
module sysctl_rate_div #(
   parameter int unsigned DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   initial begin
      assert (DIV >= 2) else $fatal(1, "sysctl_rate_div: DIV must be at least 2");
   end

   logic [CW-1:0] phase;

   assign tick = (phase == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            phase <= '0;
      else if (restart || tick) phase <= '0;
      else                   phase <= phase + CW'(1);
   end
endmodule

// File: rtl/sysctl_run_cnt.sv
module sysctl_run_cnt #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count <= '0;
      else if (load)  count <= load_val;
      else if (tick)  count <= count + W'(1);
   end
endmodule

// File: rtl/sysctl_ps_pair.sv
module sysctl_ps_pair #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         wr_reload,
   input  logic         wr_down,
   input  logic         wr_event,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] reload,
   output logic [W-1:0] down,
   output logic [W-1:0] events
);
   logic at_zero;
   assign at_zero = (down == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          reload <= '0;
      else if (wr_reload)  reload <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          down <= '0;
      else if (wr_down)    down <= wdata;
      else if (tick)       down <= at_zero ? reload : down - W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               events <= '0;
      else if (wr_event)        events <= wdata;
      else if (tick && at_zero) events <= events + W'(1);
   end
endmodule

// File: rtl/sysctl_btn_sync.sv
module sysctl_btn_sync #(
   parameter int unsigned W      = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   initial begin
      assert (STAGES >= 1) else $fatal(1, "sysctl_btn_sync: STAGES must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
   import sysctl_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 50_000_000,
   parameter int unsigned PS_HZ       = 25_000_000,
   parameter int unsigned BTN_W       = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [11:0]      bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   input  logic [BTN_W-1:0] btn_i,
   output logic [1:0]       led_o,
   output logic [31:0]      misc_o
);
   localparam int unsigned FAST_DIV = CLK_HZ / 100;
   localparam int unsigned SLOW_DIV = CLK_HZ;
   localparam int unsigned PS_DIV   = (PS_HZ == 0) ? 2 : CLK_HZ / PS_HZ;

   initial begin
      assert (CLK_HZ % 100 == 0 && FAST_DIV >= 2)
         else $fatal(1, "sysctl_regbank: CLK_HZ must be a multiple of 100 and at least 200");
      assert (PS_HZ != 0 && CLK_HZ % PS_HZ == 0 && PS_DIV >= 2)
         else $fatal(1, "sysctl_regbank: PS_HZ must divide CLK_HZ by at least 2");
      assert (BTN_W >= 1 && BTN_W <= DW)
         else $fatal(1, "sysctl_regbank: BTN_W out of range");
   end

   // access decode
   reg_sel_e sel;
   logic     wr_en, rd_en;
   assign sel   = decode_offset(bus_addr);
   assign wr_en = bus_sel &&  bus_wr;
   assign rd_en = bus_sel && !bus_wr;

   logic wr_led, wr_misc, wr_slow, wr_fast, wr_reload, wr_down, wr_event, ps_grp_wr;
   assign wr_led    = wr_en && (sel == SEL_LED);
   assign wr_misc   = wr_en && (sel == SEL_MISC);
   assign wr_slow   = wr_en && (sel == SEL_SLOW);
   assign wr_fast   = wr_en && (sel == SEL_FAST);
   assign wr_reload = wr_en && (sel == SEL_RELOAD);
   assign wr_down   = wr_en && (sel == SEL_DOWN);
   assign wr_event  = wr_en && (sel == SEL_EVT);
   assign ps_grp_wr = wr_reload || wr_down || wr_event;

   // plain storage registers
   logic [1:0]    led_q;
   logic [DW-1:0] misc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      led_q <= '0;
      else if (wr_led) led_q <= bus_wdata[1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       misc_q <= '0;
      else if (wr_misc) misc_q <= bus_wdata;
   end

   assign led_o  = led_q;
   assign misc_o = misc_q;

   // button synchroniser
   logic [BTN_W-1:0] btn_s;
   sysctl_btn_sync #(.W(BTN_W), .STAGES(SYNC_STAGES)) u_btn (
      .clk(clk), .rst_n(rst_n), .din(btn_i), .dout(btn_s)
   );

   // time base dividers
   logic fast_tick, slow_tick, ps_tick;

   sysctl_rate_div #(.DIV(FAST_DIV)) u_div_fast (
      .clk(clk), .rst_n(rst_n), .restart(wr_fast), .tick(fast_tick)
   );
   sysctl_rate_div #(.DIV(SLOW_DIV)) u_div_slow (
      .clk(clk), .rst_n(rst_n), .restart(wr_slow), .tick(slow_tick)
   );
   sysctl_rate_div #(.DIV(PS_DIV)) u_div_ps (
      .clk(clk), .rst_n(rst_n), .restart(ps_grp_wr), .tick(ps_tick)
   );

   // running counters
   logic [DW-1:0] fast_cnt, slow_cnt;

   sysctl_run_cnt #(.W(DW)) u_cnt_fast (
      .clk(clk), .rst_n(rst_n), .tick(fast_tick), .load(wr_fast),
      .load_val(bus_wdata), .count(fast_cnt)
   );
   sysctl_run_cnt #(.W(DW)) u_cnt_slow (
      .clk(clk), .rst_n(rst_n), .tick(slow_tick), .load(wr_slow),
      .load_val(bus_wdata), .count(slow_cnt)
   );

   // prescaled event counter pair
   logic [DW-1:0] ps_reload, ps_down, ps_events;

   sysctl_ps_pair #(.W(DW)) u_ps (
      .clk(clk), .rst_n(rst_n), .tick(ps_tick),
      .wr_reload(wr_reload), .wr_down(wr_down), .wr_event(wr_event),
      .wdata(bus_wdata),
      .reload(ps_reload), .down(ps_down), .events(ps_events)
   );

   // read path
   logic [DW-1:0] rd_mux;

   always_comb begin
      case (sel)
         SEL_LED:    rd_mux = DW'(led_q);
         SEL_BTN:    rd_mux = DW'(btn_s);
         SEL_SLOW:   rd_mux = slow_cnt;
         SEL_FAST:   rd_mux = fast_cnt;
         SEL_EVT:    rd_mux = ps_events;
         SEL_RELOAD: rd_mux = ps_reload;
         SEL_DOWN:   rd_mux = ps_down;
         SEL_MISC:   rd_mux = misc_q;
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bus_rdata <= '0;
      else if (rd_en) bus_rdata <= rd_mux;
   end
endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_sel,
   input logic        bus_wr,
   input logic [11:0] bus_addr,
   input logic [31:0] bus_rdata,
   input logic [1:0]  led_o,
   input logic [31:0] misc_o,
   input logic [31:0] fast_cnt,
   input logic        ps_tick,
   input logic [31:0] ps_down,
   input logic [31:0] ps_events
);
   function automatic logic known(input logic [11:0] a);
      return a inside {12'h000, 12'h008, 12'h010, 12'h014,
                       12'h018, 12'h01C, 12'h020, 12'h04C};
   endfunction

   logic wr_at_led, wr_at_misc, wr_at_fast, wr_at_down, wr_at_evt, rd_any;
   assign wr_at_led  = bus_sel && bus_wr && (bus_addr == 12'h000);
   assign wr_at_misc = bus_sel && bus_wr && (bus_addr == 12'h04C);
   assign wr_at_fast = bus_sel && bus_wr && (bus_addr == 12'h014);
   assign wr_at_down = bus_sel && bus_wr && (bus_addr == 12'h020);
   assign wr_at_evt  = bus_sel && bus_wr && (bus_addr == 12'h018);
   assign rd_any     = bus_sel && !bus_wr;

   a_r1_led_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_at_led |=> $stable(led_o));

   a_r2_misc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_at_misc |=> $stable(misc_o));

   a_r4_fast_step: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_at_fast |=> (fast_cnt == $past(fast_cnt)) || (fast_cnt == $past(fast_cnt) + 32'd1));

   a_r6_down_dec: assert property (@(posedge clk) disable iff (!rst_n)
      (ps_tick && ps_down != 32'd0 && !wr_at_down) |=> ps_down == $past(ps_down) - 32'd1);

   a_r7_event_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (ps_tick && ps_down == 32'd0 && !wr_at_evt) |=> ps_events == $past(ps_events) + 32'd1);

   a_r9_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_any && !known(bus_addr)) |=> bus_rdata == 32'd0);

   a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_any |=> $stable(bus_rdata));
endmodule

bind sysctl_regbank sysctl_regbank_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_rdata(bus_rdata), .led_o(led_o), .misc_o(misc_o),
   .fast_cnt(fast_cnt), .ps_tick(ps_tick), .ps_down(ps_down), .ps_events(ps_events)
);

// File: tb/sysctl_regbank_bench.sv
module sysctl_regbank_bench;
   localparam int unsigned CLK_HZ = 1000;
   localparam int unsigned PS_HZ  = 250;
   localparam int FDIV = CLK_HZ / 100;
   localparam int SDIV = CLK_HZ;
   localparam int PDIV = CLK_HZ / PS_HZ;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  btn_i = '0;
   logic [1:0]  led_o;
   logic [31:0] misc_o;

   always #4 clk = ~clk;

   sysctl_regbank #(.CLK_HZ(CLK_HZ), .PS_HZ(PS_HZ), .BTN_W(2), .SYNC_STAGES(2)) u_sysctl_regbank (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .btn_i(btn_i), .led_o(led_o), .misc_o(misc_o)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // scoreboard
   typedef struct {
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb[$];
   logic mon_rd = 1'b0;

   always @(posedge clk) mon_rd <= bus_sel && !bus_wr;

   always @(negedge clk) begin
      if (mon_rd) begin
         if (sb.size() == 0) begin
            check(bus_rdata, 32'hDEAD_BEEF, "scoreboard underflow");
         end else begin
            item_t it;
            it = sb.pop_front();
            check(bus_rdata, it.exp, it.tag);
         end
      end
   end

   // models
   logic [31:0] fast_v, slow_v, m_down, m_rel, m_ev;
   int fast_base, slow_base, ps_base;

   task automatic ps_step(inout logic [31:0] d, inout logic [31:0] ev, input logic [31:0] r);
      if (d == 0) begin d = r; ev = ev + 1; end
      else d = d - 1;
   endtask

   task automatic ps_peek(output logic [31:0] d, output logic [31:0] ev);
      int n;
      d = m_down; ev = m_ev;
      n = (cyc - ps_base) / PDIV;
      for (int i = 0; i < n; i++) ps_step(d, ev, m_rel);
   endtask

   task automatic bus_do(input logic w, input logic [11:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
      item_t it;
      it.exp = exp; it.tag = tag;
      sb.push_back(it);
      bus_do(1'b0, a, 32'd0);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_do(1'b1, a, d);
   endtask

   task automatic wr_fast(input logic [31:0] v);
      fast_v = v; fast_base = cyc + 1; wr(12'h014, v);
   endtask

   task automatic wr_slow(input logic [31:0] v);
      slow_v = v; slow_base = cyc + 1; wr(12'h010, v);
   endtask

   // which: 0 reload, 1 down, 2 events
   task automatic wr_ps(input int which, input logic [31:0] v);
      int e, n;
      logic [31:0] d, ev;
      e = cyc + 1;
      d = m_down; ev = m_ev;
      n = (e - 1 - ps_base) / PDIV;
      for (int i = 0; i < n; i++) ps_step(d, ev, m_rel);
      if (((e - ps_base) % PDIV) == 0) ps_step(d, ev, m_rel);
      if (which == 0) m_rel = v;
      if (which == 1) d = v;
      if (which == 2) ev = v;
      m_down = d; m_ev = ev; ps_base = e;
      wr(which == 0 ? 12'h01C : (which == 1 ? 12'h020 : 12'h018), v);
   endtask

   task automatic rd_fast(input string tag);
      rd(12'h014, fast_v + 32'((cyc - fast_base) / FDIV), tag);
   endtask

   task automatic rd_slow(input string tag);
      rd(12'h010, slow_v + 32'((cyc - slow_base) / SDIV), tag);
   endtask

   task automatic rd_ps_down(input string tag);
      logic [31:0] d, ev;
      ps_peek(d, ev);
      rd(12'h020, d, tag);
   endtask

   task automatic rd_ps_ev(input string tag);
      logic [31:0] d, ev;
      ps_peek(d, ev);
      rd(12'h018, ev, tag);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         finish_run();
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      fast_v = 0; slow_v = 0; m_down = 0; m_rel = 0; m_ev = 0;
      fast_base = cyc; slow_base = cyc; ps_base = cyc;

      // R10: reset state
      check(32'(led_o), 32'd0, "R10 led_o after reset");
      check(misc_o, 32'd0, "R10 misc_o after reset");
      rd_ps_ev("R10 events after reset");
      rd_ps_down("R10 down after reset");
      rd(12'h000, 32'd0, "R10 led reg after reset");
      rd(12'h04C, 32'd0, "R10 misc reg after reset");
      rd(12'h01C, 32'd0, "R10 reload after reset");
      rd_fast("R10 fast after reset");
      rd_slow("R10 slow after reset");

      // R1: LED masking
      wr(12'h000, 32'hFFFF_FFFF);
      check(32'(led_o), 32'd3, "R1 led_o all ones");
      rd(12'h000, 32'd3, "R1 led readback masked");
      wr(12'h000, 32'h0000_0006);
      check(32'(led_o), 32'd2, "R1 led_o bit1 only");
      rd(12'h000, 32'd2, "R1 led readback 2");

      // R2: control word
      wr(12'h04C, 32'hA5C3_0F12);
      check(misc_o, 32'hA5C3_0F12, "R2 misc_o");
      rd(12'h04C, 32'hA5C3_0F12, "R2 misc readback");

      // R3: buttons
      btn_i = 2'b10; idle(3);
      rd(12'h008, 32'd2, "R3 button 10");
      btn_i = 2'b01; idle(3);
      wr(12'h008, 32'hFFFF_FFFF);
      rd(12'h008, 32'd1, "R3 button 01 after write");
      btn_i = 2'b00;

      // R4: 100 Hz counter
      wr_fast(32'd100);
      idle(3);  rd_fast("R4 fast shortly after load");
      idle(25); rd_fast("R4 fast after 2 periods");
      wr_fast(32'hFFFF_FFFF);
      idle(14); rd_fast("R4 fast wrap");
      idle(37); rd_fast("R4 fast later");

      // R5: 1 Hz counter
      wr_slow(32'd41);
      idle(5);    rd_slow("R5 slow right after load");
      idle(2400); rd_slow("R5 slow after two periods");

      // R6, R8: prescale pair
      wr_ps(0, 32'd3);
      wr_ps(1, 32'd5);
      wr_ps(2, 32'd100);
      rd(12'h01C, 32'd3, "R8 reload readback");
      idle(7);  rd_ps_down("R6 down mid count");
      idle(13); rd_ps_ev("R6 events after reload");
      rd_ps_down("R6 down after reload");
      idle(40); rd_ps_ev("R6 events later");

      // R7: reload zero
      wr_ps(0, 32'd0);
      wr_ps(1, 32'd2);
      wr_ps(2, 32'hFFFF_FFFF);
      idle(20); rd_ps_ev("R7 events wrap with zero reload");
      rd_ps_down("R7 down sticks at zero");

      // R9: undefined offsets
      wr(12'h004, 32'hFFFF_FFFF);
      wr(12'h001, 32'hFFFF_FFFF);
      wr(12'h04D, 32'h1234_5678);
      wr(12'h01E, 32'h0000_0077);
      wr(12'hFFC, 32'hFFFF_FFFF);
      rd(12'h000, 32'd2, "R9 led unchanged");
      rd(12'h04C, 32'hA5C3_0F12, "R9 misc unchanged");
      rd(12'h01C, 32'd0, "R9 reload unchanged");
      rd(12'h004, 32'd0, "R9 read 0x004");
      rd(12'h001, 32'd0, "R9 read unaligned");
      rd(12'h050, 32'd0, "R9 read 0x050");
      rd(12'hFFC, 32'd0, "R9 read 0xFFC");

      // R11: read data hold
      rd(12'h04C, 32'hA5C3_0F12, "R11 misc read");
      idle(5);
      check(bus_rdata, 32'hA5C3_0F12, "R11 hold through idle");
      wr(12'h04C, 32'h0000_0001);
      check(bus_rdata, 32'hA5C3_0F12, "R11 hold through write");

      idle(3);
      check(32'(sb.size()), 32'd0, "scoreboard drained");
      done = 1;
      finish_run();
   end
endmodule